// File: doc/BRIEF.md
# Paced Multichannel Scan Acquirer

This block runs data acquisition for a front end that converts four analog channels at the same instant. A microsecond pacing timer sets how often a scan is taken. When the timer expires, the block raises a one-cycle convert request. It then waits for a result beat that carries all four signed 16-bit conversions, latches that beat, and sends the four samples into a downstream sample FIFO one word at a time, lowest channel first. Software sets the scan period in whole microseconds. A 32-bit counter reports how many scans have been fully handed over.

Both data paths use valid/ready. On the result input, the block raises `res_ready` only while it waits for a conversion. A result beat is taken in the cycle where `res_valid` and `res_ready` are both high, and the ADC must hold the beat until then. On the write output, a word is on offer while `wr_valid` is high. It moves in a cycle where `wr_ready` is also high. The downstream FIFO, sized for 12,000 signed 16-bit entries, drops `wr_ready` when it is full. The block then keeps offering the same word. It never skips a word and never overwrites one, so acquisition slows down until space frees up. A status flag reports the blocked condition.

Each convert request waits for the full pacing delay. This holds for the first scan after enable as well. If a stall holds a scan past its slot, the timer restarts when that scan completes, so no burst of back-to-back scans follows.

Top module: `scan_acquirer`

## Requirements
- R1: After reset, `conv_req`, `res_ready`, `wr_valid` and `fifo_blocked` are low and `scan_count` is zero.
- R2: The first convert request after `enable` rises comes no sooner than period × CYC_PER_US clock cycles later (period in microseconds), and at most two cycles after that.
- R3: With a ready FIFO and a prompt ADC, successive convert requests are exactly period × CYC_PER_US cycles apart, and each request lasts one cycle.
- R4: A `period_us` of zero behaves exactly like a period of one microsecond.
- R5: `res_ready` is high only while a conversion result is awaited. Exactly one result beat is taken per convert request, and `res_ready` drops in the cycle after the handshake.
- R6: Each scan gives exactly four writes, in order: channel 0 from `res_data[15:0]`, then channel 1 from `[31:16]`, channel 2 from `[47:32]` and channel 3 from `[63:48]`.
- R7: While `wr_ready` is low, `wr_valid` stays high and `wr_data` stays the same. No word is lost or replaced, and no new convert request is issued.
- R8: `fifo_blocked` is high in the cycle after a word was offered and refused, and low in the cycle after any cycle without a refusal.
- R9: `scan_count` rises by exactly one when the fourth word of a scan is accepted, and does not change at any other time.
- R10: If a scan finishes after its next pacing slot has already passed, the next convert request comes period × CYC_PER_US cycles after the final word is accepted, to within two cycles.
- R11: While `enable` is low, no new convert request is issued. A scan already under way still completes all four writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs paced acquisition while high |
| period_us | input | PER_W | Scan period in microseconds (0 acts as 1) |
| conv_req | output | 1 | One-cycle convert request to the ADC |
| res_valid | input | 1 | ADC result beat valid |
| res_ready | output | 1 | Block is ready to take a result beat |
| res_data | input | NCH×SW | Four packed signed samples, channel 0 in the low bits |
| wr_valid | output | 1 | Sample word offered to the FIFO |
| wr_ready | input | 1 | FIFO can accept a word (low when full) |
| wr_data | output | SW | Signed sample word |
| fifo_blocked | output | 1 | Previous cycle's word offer was refused |
| scan_count | output | CNT_W | Number of completed scans |

## Verification
A fault in the write sequencer's index or hold logic shows up within one word: a repeated, skipped or changed `wr_data` word, seen while the FIFO stalls or right after a result beat. A fault in the pacing timer shows up at the next convert request as a gap other than period × 200 cycles. A fault in the late-scan restart shows up as a request that follows a stalled scan too early. A fault in the scan counter shows up as a count that disagrees with the number of fourth-word handshakes, as soon as the next scan completes.

// File: rtl/scan_acq_pkg.sv
package scan_acq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_REQ,
    ST_CONV,
    ST_SEND
  } seq_state_t;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/scan_pacer.sv
module scan_pacer #(
  parameter int CYC_PER_US = 200,
  parameter int PER_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PER_W-1:0] period_us,
  output logic             expire
);
  localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;

  logic             us_tick;
  logic [PER_W-1:0] us_q;
  logic [PER_W-1:0] per_eff;

  // microsecond clock-enable, cleared on restart so the delay is exact
  generate
    if (CYC_PER_US > 1) begin : g_prescale
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_US - 1);
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (!rst_n || restart)    pre_q <= '0;
        else if (pre_q == PRE_LAST) pre_q <= '0;
        else                        pre_q <= pre_q + 1'b1;
      end
      assign us_tick = (pre_q == PRE_LAST);
    end else begin : g_direct
      assign us_tick = 1'b1;
    end
  endgenerate

  assign per_eff = (period_us == '0) ? PER_W'(1) : period_us;
  assign expire  = us_tick && (us_q == per_eff - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || restart || expire) us_q <= '0;
    else if (us_tick)                us_q <= us_q + 1'b1;
  end
endmodule

// File: rtl/scan_capture.sv
module scan_capture #(
  parameter int NCH = 4,
  parameter int SW  = 16
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      load,
  input  logic [NCH*SW-1:0]                         in_data,
  input  logic [scan_acq_pkg::idx_width(NCH)-1:0]   sel,
  output logic [SW-1:0]                             word
);
  logic [SW-1:0] lane_q [NCH];

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_lane
      always_ff @(posedge clk) begin
        if (!rst_n)    lane_q[c] <= '0;
        else if (load) lane_q[c] <= in_data[c*SW +: SW];
      end
    end
  endgenerate

  assign word = lane_q[sel];
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_acq_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           enable,
  input  logic                           expire,
  input  logic                           res_valid,
  input  logic                           wr_ready,
  output logic                           restart,
  output logic                           conv_req,
  output logic                           res_ready,
  output logic                           load,
  output logic [idx_width(NCH)-1:0]      sel,
  output logic                           wr_valid,
  output logic                           scan_done
);
  localparam int                  IDX_W = idx_width(NCH);
  localparam logic [IDX_W-1:0]    LAST  = IDX_W'(NCH - 1);

  seq_state_t       state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic             late_q;

  assign conv_req  = (state_q == ST_REQ);
  assign res_ready = (state_q == ST_CONV);
  assign wr_valid  = (state_q == ST_SEND);
  assign load      = res_ready && res_valid;
  assign scan_done = wr_valid && wr_ready && (idx_q == LAST);
  assign sel       = idx_q;

  always_comb begin
    state_d = state_q;
    restart = 1'b0;
    unique case (state_q)
      ST_IDLE: if (enable) begin
        restart = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (!enable)     state_d = ST_IDLE;
        else if (expire) state_d = ST_REQ;
      end
      ST_REQ:  state_d = ST_CONV;
      ST_CONV: if (res_valid) state_d = ST_SEND;
      ST_SEND: if (scan_done) begin
        state_d = enable ? ST_WAIT : ST_IDLE;
        restart = late_q;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      late_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load)                      idx_q <= '0;
      else if (wr_valid && wr_ready) idx_q <= idx_q + 1'b1;
      if (restart || state_q == ST_IDLE)
        late_q <= 1'b0;
      else if (expire && state_q != ST_WAIT)
        late_q <= 1'b1;
    end
  end
endmodule

// File: rtl/scan_acquirer.sv
module scan_acquirer #(
  parameter int NCH        = 4,
  parameter int SW         = 16,
  parameter int CYC_PER_US = 200,
  parameter int PER_W      = 32,
  parameter int CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [PER_W-1:0]  period_us,
  output logic              conv_req,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [NCH*SW-1:0] res_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [SW-1:0]     wr_data,
  output logic              fifo_blocked,
  output logic [CNT_W-1:0]  scan_count
);
  localparam int IDX_W = scan_acq_pkg::idx_width(NCH);

  logic             restart, expire, load, scan_done;
  logic [IDX_W-1:0] sel;

  scan_pacer #(.CYC_PER_US(CYC_PER_US), .PER_W(PER_W)) i_pacer (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .period_us(period_us), .expire(expire)
  );

  scan_ctrl #(.NCH(NCH)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .expire(expire),
    .res_valid(res_valid), .wr_ready(wr_ready), .restart(restart),
    .conv_req(conv_req), .res_ready(res_ready), .load(load),
    .sel(sel), .wr_valid(wr_valid), .scan_done(scan_done)
  );

  scan_capture #(.NCH(NCH), .SW(SW)) i_capture (
    .clk(clk), .rst_n(rst_n), .load(load), .in_data(res_data),
    .sel(sel), .word(wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_count   <= '0;
      fifo_blocked <= 1'b0;
    end else begin
      if (scan_done) scan_count <= scan_count + 1'b1;
      fifo_blocked <= wr_valid && !wr_ready;
    end
  end
endmodule

// File: rtl/scan_acq_chk.sv
module scan_acq_chk #(
  parameter int NCH        = 4,
  parameter int SW         = 16,
  parameter int CYC_PER_US = 200,
  parameter int PER_W      = 32,
  parameter int CNT_W      = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [PER_W-1:0]  period_us,
  input logic              conv_req,
  input logic              res_valid,
  input logic              res_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [SW-1:0]     wr_data,
  input logic              fifo_blocked,
  input logic [CNT_W-1:0]  scan_count
);
  logic [63:0] gap_q;
  logic [63:0] min_gap;

  assign min_gap = 64'((period_us == '0) ? 1 : period_us) * 64'(CYC_PER_US) - 64'd1;

  always_ff @(posedge clk) begin
    if (!rst_n || conv_req || !enable) gap_q <= '0;
    else                               gap_q <= gap_q + 64'd1;
  end

  // R2
  pace_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> gap_q >= min_gap);

  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);

  // R5
  res_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> !res_ready);

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));

  // R8
  blocked_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_blocked |-> wr_valid);

  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) |=> $stable(scan_count));

  // R11
  idle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !conv_req);
endmodule

bind scan_acquirer scan_acq_chk #(
  .NCH(NCH), .SW(SW), .CYC_PER_US(CYC_PER_US), .PER_W(PER_W), .CNT_W(CNT_W)
) i_scan_acq_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .period_us(period_us),
  .conv_req(conv_req), .res_valid(res_valid), .res_ready(res_ready),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
  .fifo_blocked(fifo_blocked), .scan_count(scan_count)
);

// File: tb/test_scan_acquirer.sv
module test_scan_acquirer;
  localparam int T = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [31:0] period_us = 32'd1;
  logic        conv_req, res_ready, wr_valid, fifo_blocked;
  logic        res_valid = 1'b0;
  logic [63:0] res_data = '0;
  logic        wr_ready = 1'b1;
  logic [15:0] wr_data;
  logic [31:0] scan_count;

  int n_chk = 0, n_bad = 0;
  longint cyc = 0;
  longint req_cyc [0:63];
  int     req_n = 0;
  logic [15:0] got [0:255];
  int     got_n = 0;
  longint last_hs = 0;
  int     adc_s = 0;

  always #2.5 clk = ~clk;

  scan_acquirer i_scan_acquirer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .period_us(period_us),
    .conv_req(conv_req), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .fifo_blocked(fifo_blocked), .scan_count(scan_count)
  );

  function automatic logic [15:0] exp_w(input int s, input int c);
    return 16'hA500 ^ 16'(s * 16 + c);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (conv_req && req_n < 64) begin
      req_cyc[req_n] = cyc;
      req_n++;
    end
    if (wr_valid && wr_ready) begin
      if (got_n < 256) got[got_n] = wr_data;
      got_n++;
      last_hs = cyc;
    end
  end

  // ADC model: answers each request after two cycles, holds until taken
  initial begin
    forever begin
      @(negedge clk);
      if (conv_req) begin
        repeat (2) @(negedge clk);
        res_valid = 1'b1;
        for (int c = 0; c < 4; c++) res_data[c*16 +: 16] = exp_w(adc_s, c);
        while (!res_ready) @(negedge clk);
        @(negedge clk);
        res_valid = 1'b0;
        adc_s++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_words(input string req, input int gbase, input int sbase, input int n);
    for (int k = 0; k < n; k++)
      chk(got[gbase + k] == exp_w(sbase + k / 4, k % 4), req,
          longint'(got[gbase + k]), longint'(exp_w(sbase + k / 4, k % 4)));
  endtask

  task automatic t_reset();
    chk(conv_req == 1'b0, "R1 conv_req", conv_req, 0);
    chk(res_ready == 1'b0, "R1 res_ready", res_ready, 0);
    chk(wr_valid == 1'b0, "R1 wr_valid", wr_valid, 0);
    chk(fifo_blocked == 1'b0, "R1 fifo_blocked", fifo_blocked, 0);
    chk(scan_count == 0, "R1 scan_count", scan_count, 0);
  endtask

  // R2 R3 R4 R6 R9 R11: four paced scans, then disable
  task automatic t_pacing(input int per, input string tag);
    int p_eff = (per == 0) ? 1 : per;
    int rb, gb, sb;
    longint c0;
    logic [31:0] sc0;
    @(negedge clk);
    period_us = 32'(per);
    rb = req_n; gb = got_n; sb = adc_s; sc0 = scan_count;
    c0 = cyc;
    enable = 1'b1;
    while (req_n < rb + 4) @(negedge clk);
    enable = 1'b0;
    chk(req_cyc[rb] - c0 >= p_eff * T && req_cyc[rb] - c0 <= p_eff * T + 2,
        {tag, " R2 first delay"}, req_cyc[rb] - c0, p_eff * T + 1);
    for (int i = 1; i < 4; i++)
      chk(req_cyc[rb + i] - req_cyc[rb + i - 1] == p_eff * T,
          {tag, " R3 interval"}, req_cyc[rb + i] - req_cyc[rb + i - 1], p_eff * T);
    repeat (40) @(negedge clk);
    chk(got_n - gb == 16, {tag, " R11 last scan completes"}, got_n - gb, 16);
    check_words({tag, " R6 word order"}, gb, sb, 16);
    chk(scan_count == sc0 + 4, {tag, " R9 scan_count"}, scan_count, sc0 + 4);
    repeat (3 * T) @(negedge clk);
    chk(req_n == rb + 4, {tag, " R11 no request when disabled"}, req_n, rb + 4);
  endtask

  // R7 R8 R9 R10: FIFO stall during a scan
  task automatic t_stall();
    int rb, gb, sb;
    logic [31:0] sc0;
    logic [15:0] held;
    bit bad = 0;
    @(negedge clk);
    period_us = 32'd1;
    wr_ready = 1'b0;
    rb = req_n; gb = got_n; sb = adc_s; sc0 = scan_count;
    enable = 1'b1;
    while (!wr_valid) @(negedge clk);
    held = wr_data;
    @(negedge clk);
    chk(fifo_blocked == 1'b1, "R8 blocked while refused", fifo_blocked, 1);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (!wr_valid || wr_data != held) bad = 1;
    end
    chk(!bad, "R7 word held during stall", bad, 0);
    chk(held == exp_w(sb, 0), "R7 held word is channel 0", held, exp_w(sb, 0));
    chk(req_n == rb + 1, "R7 no request while stalled", req_n, rb + 1);
    chk(scan_count == sc0, "R9 count frozen in stall", scan_count, sc0);
    wr_ready = 1'b1;
    while (req_n < rb + 2) @(negedge clk);
    chk(req_cyc[rb + 1] - last_hs >= T && req_cyc[rb + 1] - last_hs <= T + 2,
        "R10 no catch-up after stall", req_cyc[rb + 1] - last_hs, T + 1);
    chk(fifo_blocked == 1'b0, "R8 blocked clears", fifo_blocked, 0);
    check_words("R7 stalled scan order", gb, sb, 4);
    chk(scan_count == sc0 + 1, "R9 count after stall", scan_count, sc0 + 1);
    enable = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  // R11 R5: disable right at the request; scan still completes once
  task automatic t_disable();
    int rb, gb, sb;
    logic [31:0] sc0;
    @(negedge clk);
    period_us = 32'd1;
    rb = req_n; gb = got_n; sb = adc_s; sc0 = scan_count;
    enable = 1'b1;
    while (!conv_req) @(negedge clk);
    enable = 1'b0;
    repeat (40) @(negedge clk);
    chk(got_n - gb == 4, "R11 scan finishes after disable", got_n - gb, 4);
    chk(adc_s - sb == 1, "R5 one result beat per request", adc_s - sb, 1);
    chk(res_ready == 1'b0, "R5 res_ready idle", res_ready, 0);
    check_words("R6 order after disable", gb, sb, 4);
    chk(scan_count == sc0 + 1, "R9 count after disable", scan_count, sc0 + 1);
    repeat (2 * T) @(negedge clk);
    chk(req_n == rb + 1, "R11 no further request", req_n, rb + 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_pacing(3, "period3");
    t_pacing(0, "R4 period0");
    t_pacing(1, "period1");
    t_stall();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule